// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads bytes out of a one-time-programmable fuse macro without software toggling the macro's pins. A client asks for a burst by giving a start offset and a byte count. The sequencer then steps through a fixed pin sequence:

1. A load phase opens the burst.
2. For each byte it sets up the address, raises the strobe, captures the macro's data output and releases the strobe.
3. When the last byte is done, it parks the pins in standby.

Every step is followed by a settling interval. The length of that interval comes from a cycle count on an input pin, so one netlist can serve any clock rate. For example, a count of 100 gives about 1 us at 100 MHz.

Bytes leave through a valid/ready stream. Each byte carries the offset it was read from. A byte is transferred on a cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, the byte is held: `out_valid`, `out_data` and `out_offset` do not change, the strobe stays high and the sequence stalls. The fuse contents cannot be changed through this block. A write request is acknowledged one cycle later and otherwise does nothing.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, the pins are in standby: `fuse_csb`=1, `fuse_pgenb`=1, `fuse_load`=0, `fuse_strobe`=0 and `fuse_addr`=0. In this state `busy`=0 and `out_valid`=0.
- R2: A start with a non-zero count, taken while idle, makes `busy` go high on the next clock edge. For the whole burst the pins then stay at `fuse_csb`=0, `fuse_load`=1 and `fuse_pgenb`=1. The first strobe rises exactly 2*N cycles after `fuse_csb` falls: one load interval and one address interval. Here N is the settle count.
- R3: Once the strobe rises, it stays high for N cycles plus the cycles in which the byte waits for a handshake, plus the handshake cycle itself. `fuse_addr` does not change while the strobe is high.
- R4: Each byte presented is the value of `fuse_dout` in the last cycle of the strobe interval. It is presented together with its full-width offset, and `fuse_addr` equals the low ADDR_W bits of that offset.
- R5: After each handshake the strobe stays low for exactly 2*N cycles before the next byte's strobe: a release interval followed by an address interval. The offset increases by one per byte and wraps at OFS_W bits. The address wraps at ADDR_W bits.
- R6: After the last byte's release interval, `busy` falls and the pins return to the standby state of R1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_offset` hold their values on the next cycle, and the strobe stays high.
- R8: A start request while `busy` is high is ignored. The burst in progress produces exactly its own bytes.
- R9: A start with a count of zero leaves `busy` low, the pins in standby and `out_valid` low.
- R10: `wr_ack` is high exactly one cycle after `wr_req`. A write request changes no pin, no output byte and no offset.
- R11: A settle count of zero is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| settle_cycles | input | TMR_W | Settling interval N in cycles (0 acts as 1) |
| req_start | input | 1 | Start a read burst (taken only when idle) |
| req_offset | input | OFS_W | First byte offset |
| req_count | input | LEN_W | Number of bytes to read |
| wr_req | input | 1 | Write request (acknowledged, no effect) |
| wr_ack | output | 1 | Write acknowledge, one cycle after `wr_req` |
| busy | output | 1 | A burst is running |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Byte read from the fuses |
| out_offset | output | OFS_W | Offset of the byte |
| fuse_csb | output | 1 | Macro chip select, active low |
| fuse_pgenb | output | 1 | Macro program disable (kept high) |
| fuse_load | output | 1 | Macro load enable |
| fuse_strobe | output | 1 | Macro read strobe |
| fuse_addr | output | ADDR_W | Macro byte address |
| fuse_dout | input | 8 | Macro data output |

## Verification
The bench builds the block with ADDR_W=10, OFS_W=12, LEN_W=5 and TMR_W=4. Because the offset is wider than the address, bursts that cross the 1024-byte address wrap and the 4096 offset wrap can both be reached in a few hundred cycles. The 4-bit settle count keeps each interval short, and it still covers the zero-as-one case as well as counts of 1, 2 and 3. A 5-bit count allows a 31-byte burst, which exercises the longest sequence this build supports.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_REL
  } seq_state_e;

  typedef struct packed {
    logic csb;
    logic pgenb;
    logic load;
    logic strobe;
  } fuse_pins_t;

  localparam fuse_pins_t PINS_STANDBY = '{csb: 1'b1, pgenb: 1'b1, load: 1'b0, strobe: 1'b0};

endpackage

// File: rtl/fuse_settle_timer.sv
module fuse_settle_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [TMR_W-1:0] settle_cycles,
  output logic             done
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      // An interval of N cycles ends when the counter reaches zero.
      cnt_q <= (settle_cycles == '0) ? '0 : settle_cycles - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fuse_byte_cursor.sv
module fuse_byte_cursor #(
  parameter int OFS_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] load_offset,
  input  logic [LEN_W-1:0] load_count,
  input  logic             step,
  output logic [OFS_W-1:0] offset,
  output logic             empty
);
  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      ofs_q  <= load_offset;
      left_q <= load_count;
    end else if (step) begin
      ofs_q  <= ofs_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign offset = ofs_q;
  assign empty  = (left_q == '0);
endmodule

// File: rtl/fuse_seq_fsm.sv
module fuse_seq_fsm
  import fuse_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       tmr_done,
  input  logic       out_ready,
  input  logic       cursor_empty,
  output seq_state_e state,
  output seq_state_e state_next,
  output logic       tmr_restart,
  output logic       capture,
  output logic       step
);
  seq_state_e st_q, st_n;

  always_comb begin
    st_n        = st_q;
    tmr_restart = 1'b0;
    capture     = 1'b0;
    step        = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_n        = ST_LOAD;
        tmr_restart = 1'b1;
      end
      ST_LOAD: if (tmr_done) begin
        st_n        = ST_ADDR;
        tmr_restart = 1'b1;
      end
      ST_ADDR: if (tmr_done) begin
        st_n        = ST_STRB;
        tmr_restart = 1'b1;
      end
      ST_STRB: if (tmr_done) begin
        st_n    = ST_HOLD;
        capture = 1'b1;
      end
      ST_HOLD: if (out_ready) begin
        st_n        = ST_REL;
        tmr_restart = 1'b1;
        step        = 1'b1;
      end
      ST_REL: if (tmr_done) begin
        st_n        = cursor_empty ? ST_IDLE : ST_ADDR;
        tmr_restart = !cursor_empty;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign state      = st_q;
  assign state_next = st_n;
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 16,
  parameter int LEN_W  = 8,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  settle_cycles,
  input  logic              req_start,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]  req_count,
  input  logic              wr_req,
  output logic              wr_ack,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [OFS_W-1:0]  out_offset,
  output logic              fuse_csb,
  output logic              fuse_pgenb,
  output logic              fuse_load,
  output logic              fuse_strobe,
  output logic [ADDR_W-1:0] fuse_addr,
  input  logic [7:0]        fuse_dout
);
  seq_state_e       state, state_next;
  logic             go, tmr_restart, tmr_done, capture, step, cur_empty;
  logic [OFS_W-1:0] cur_ofs;
  fuse_pins_t       pins_q, pins_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]       data_q;
  logic             wr_ack_q;

  assign go = req_start && (state == ST_IDLE) && (req_count != '0);

  fuse_settle_timer #(.TMR_W(TMR_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .settle_cycles(settle_cycles), .done(tmr_done)
  );

  fuse_byte_cursor #(.OFS_W(OFS_W), .LEN_W(LEN_W)) i_cursor (
    .clk(clk), .rst_n(rst_n), .load(go), .load_offset(req_offset),
    .load_count(req_count), .step(step), .offset(cur_ofs), .empty(cur_empty)
  );

  fuse_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .tmr_done(tmr_done),
    .out_ready(out_ready), .cursor_empty(cur_empty), .state(state),
    .state_next(state_next), .tmr_restart(tmr_restart), .capture(capture),
    .step(step)
  );

  // Pins are registered from the next state so the macro sees clean levels.
  always_comb begin
    pins_n = PINS_STANDBY;
    addr_n = '0;
    if (state_next != ST_IDLE) begin
      pins_n.csb  = 1'b0;
      pins_n.load = 1'b1;
    end
    if (state_next inside {ST_STRB, ST_HOLD}) pins_n.strobe = 1'b1;
    if (state_next inside {ST_ADDR, ST_STRB, ST_HOLD, ST_REL})
      addr_n = cur_ofs[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= PINS_STANDBY;
      addr_q   <= '0;
      data_q   <= '0;
      wr_ack_q <= 1'b0;
    end else begin
      pins_q   <= pins_n;
      addr_q   <= addr_n;
      wr_ack_q <= wr_req;
      if (capture) data_q <= fuse_dout;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign out_valid   = (state == ST_HOLD);
  assign out_data    = data_q;
  assign out_offset  = cur_ofs;
  assign wr_ack      = wr_ack_q;
  assign fuse_csb    = pins_q.csb;
  assign fuse_pgenb  = pins_q.pgenb;
  assign fuse_load   = pins_q.load;
  assign fuse_strobe = pins_q.strobe;
  assign fuse_addr   = addr_q;
endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [OFS_W-1:0]  out_offset,
  input logic              wr_req,
  input logic              wr_ack,
  input logic              fuse_csb,
  input logic              fuse_pgenb,
  input logic              fuse_load,
  input logic              fuse_strobe,
  input logic [ADDR_W-1:0] fuse_addr
);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && !out_valid));

  // R2
  active_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!fuse_csb && fuse_pgenb && fuse_load));

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

  // R7
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && fuse_strobe && $stable(out_data) && $stable(out_offset)));

  // R4
  valid_under_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fuse_strobe && fuse_addr == out_offset[ADDR_W-1:0]));

  // R10
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> wr_ack);
endmodule

bind fuse_read_seq fuse_read_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_fuse_read_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_offset(out_offset), .wr_req(wr_req), .wr_ack(wr_ack),
  .fuse_csb(fuse_csb), .fuse_pgenb(fuse_pgenb), .fuse_load(fuse_load),
  .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr)
);

// File: tb/test_fuse_read_seq.sv
module test_fuse_read_seq;
  localparam int ADDR_W = 10;
  localparam int OFS_W  = 12;
  localparam int LEN_W  = 5;
  localparam int TMR_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TMR_W-1:0]  settle_cycles = 4'd3;
  logic              req_start = 1'b0;
  logic [OFS_W-1:0]  req_offset = '0;
  logic [LEN_W-1:0]  req_count = '0;
  logic              wr_req = 1'b0;
  logic              wr_ack, busy, out_valid;
  logic              out_ready = 1'b1;
  logic [7:0]        out_data;
  logic [OFS_W-1:0]  out_offset;
  logic              fuse_csb, fuse_pgenb, fuse_load, fuse_strobe;
  logic [ADDR_W-1:0] fuse_addr;
  logic [7:0]        fuse_dout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  logic [OFS_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] fuse_val(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {4{a[9:8]}} ^ 8'hA5;
  endfunction

  // Fuse macro model: data appears only while selected and strobed.
  assign fuse_dout = (!fuse_csb && fuse_strobe) ? fuse_val(fuse_addr) : 8'h00;

  fuse_read_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .TMR_W(TMR_W)) i_fuse_read_seq (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles), .req_start(req_start),
    .req_offset(req_offset), .req_count(req_count), .wr_req(wr_req), .wr_ack(wr_ack),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_offset(out_offset), .fuse_csb(fuse_csb), .fuse_pgenb(fuse_pgenb),
    .fuse_load(fuse_load), .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr),
    .fuse_dout(fuse_dout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // Monitor: scoreboard and pin timing.
  int hi_cnt = 0, stall_cnt = 0, lo_cnt = 0;
  bit prev_strobe = 1'b0;
  always @(negedge clk) begin
    int neff;
    neff = (settle_cycles == 0) ? 1 : int'(settle_cycles);
    if (rst_n) begin
      if (busy)
        check(!fuse_csb && fuse_load && fuse_pgenb, "R2", "active pins",
              {fuse_csb, fuse_load, fuse_pgenb}, 3'b011);
      else
        check(fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && fuse_addr == 0 && !out_valid,
              "R6", "standby pins", {fuse_csb, fuse_pgenb, fuse_load, fuse_strobe}, 4'b1100);
      if (fuse_csb) lo_cnt = 0;
      else if (!fuse_strobe) lo_cnt++;
      if (fuse_strobe) begin
        hi_cnt++;
        if (out_valid && !out_ready) stall_cnt++;
      end
      if (fuse_strobe && !prev_strobe) begin
        // R2 / R5: 2*N low cycles before each strobe
        check(lo_cnt == 2 * neff, "R5", "strobe low gap", lo_cnt, 2 * neff);
        lo_cnt = 0;
      end
      if (!fuse_strobe && prev_strobe) begin
        check(hi_cnt == neff + stall_cnt + 1, "R3", "strobe width", hi_cnt, neff + stall_cnt + 1);
        hi_cnt = 0;
        stall_cnt = 0;
      end
      prev_strobe = fuse_strobe;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected byte", out_offset, 0);
        end else begin
          logic [OFS_W-1:0] eo;
          eo = exp_q.pop_front();
          check(out_offset == eo, "R5", "offset", out_offset, eo);
          check(out_data == fuse_val(eo[ADDR_W-1:0]), "R4", "data",
                out_data, fuse_val(eo[ADDR_W-1:0]));
          check(fuse_addr == eo[ADDR_W-1:0], "R4", "address", fuse_addr, eo[ADDR_W-1:0]);
        end
      end
    end
  end

  task automatic pulse_start(input logic [OFS_W-1:0] ofs, input logic [LEN_W-1:0] cnt);
    @(negedge clk);
    req_start  = 1'b1;
    req_offset = ofs;
    req_count  = cnt;
    @(negedge clk);
    req_start  = 1'b0;
  endtask

  task automatic run_burst(input logic [OFS_W-1:0] ofs, input logic [LEN_W-1:0] cnt);
    for (int k = 0; k < int'(cnt); k++) exp_q.push_back(ofs + OFS_W'(k));
    pulse_start(ofs, cnt);
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R6", "bytes left at end", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && fuse_addr == 0,
          "R1", "reset pins", {fuse_csb, fuse_pgenb, fuse_load, fuse_strobe}, 4'b1100);
    check(!busy && !out_valid, "R1", "reset busy/valid", {busy, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_burst(12'h005, 5'd4);
    // R7: back-pressure with address wrap at 10 bits
    stall_mode = 1'b1;
    run_burst(12'h3FE, 5'd5);
    stall_mode = 1'b0;

    // R8: start while busy ignored
    for (int k = 0; k < 3; k++) exp_q.push_back(12'h040 + OFS_W'(k));
    pulse_start(12'h040, 5'd3);
    repeat (6) @(negedge clk);
    req_start = 1'b1; req_offset = 12'h700; req_count = 5'd7;
    @(negedge clk);
    req_start = 1'b0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && !busy, "R8", "extra activity", exp_q.size(), 0);

    // R9: zero count
    pulse_start(12'h123, 5'd0);
    for (int k = 0; k < 8; k++) begin
      check(!busy && fuse_csb && !out_valid, "R9", "zero count idle", {busy, fuse_csb, out_valid}, 3'b010);
      @(negedge clk);
    end

    // R10: write while idle and during a burst
    wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    check(wr_ack == 1'b1, "R10", "write ack", wr_ack, 1);
    check(fuse_csb && !fuse_load && !busy, "R10", "write no pin change", {fuse_csb, fuse_load}, 2'b10);
    @(negedge clk);
    check(wr_ack == 1'b0, "R10", "ack one cycle", wr_ack, 0);
    fork
      run_burst(12'h200, 5'd2);
      begin
        repeat (5) @(negedge clk);
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        check(wr_ack == 1'b1, "R10", "write ack busy", wr_ack, 1);
      end
    join

    // R11: zero settle acts as one
    settle_cycles = 4'd0;
    run_burst(12'h100, 5'd3);
    settle_cycles = 4'd1;
    run_burst(12'hFFE, 5'd3);
    settle_cycles = 4'd2;
    stall_mode = 1'b1;
    run_burst(12'h0F0, 5'd31);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule